// File: doc/BRIEF.md
# Auto-Reload Interval Interrupt Timer

This block divides the processor clock by a programmable 24-bit value and produces an active-low periodic interrupt. It serves as a tick source for an operating system or scheduler. Software stores the division value one byte at a time through a byte-wide write port. It selects the output style with 4-bit command codes: edge (one-clock low pulses) or level (held low until acknowledged). A further command turns all output off.

A down counter reloads itself from the stored value at each terminal count, so the interval between ticks equals the stored value in clock cycles. Writing either of the two lower bytes only changes the stored value, and the new value takes effect at the next reload. Writing the top byte loads the counter at once, so the new interval starts on that cycle. While the timer is off, the counter keeps tracking the stored value. A re-enabled timer therefore waits one full interval before its first tick.

Top module: `reload_tick_timer`

## Requirements
- R1: While reset is high and after its release, `irq_n` is high, the stored value is zero and the timer is off.
- R2: Once enabled with a stored value N (N >= 2), terminal counts occur every N clock cycles.
- R3: In edge mode (code 4'b1110), each terminal count drives `irq_n` low for exactly one cycle, starting the cycle after the counting edge.
- R4: In level mode (code 4'b1010), a terminal count drives `irq_n` low, and it stays low until an acknowledge (code 4'b1000) is applied.
- R5: A write to byte lane 0 (bits 7:0) or lane 1 (bits 15:8) changes only the stored value. The running countdown is not disturbed, and the new value is used from the next reload.
- R6: A write to byte lane 2 (bits 23:16) loads the full new value into the counter on that edge, so the next terminal count comes N cycles later.
- R7: The off command (code 4'b1100) forces `irq_n` high. While off, the counter follows the stored value, so the first tick after an enable command comes N cycles after the enable edge.
- R8: While both the stored value and the counter are zero, no terminal count occurs. If a nonzero value is then written, the counter loads it on the following clock and resumes counting.
- R9: A terminal count while a level interrupt is pending keeps `irq_n` low and queues nothing, so a single acknowledge releases it.
- R10: If an acknowledge and a level-mode terminal count fall on the same edge, the terminal count wins and `irq_n` stays low.
- R11: Command codes other than the four listed, and writes with lane select 3, have no effect.
- R12: Any mode command (level, edge or off) clears a pending level interrupt on the edge it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe for the stored value |
| wr_sel | input | 2 | Byte lane select: 0 low, 1 middle, 2 top |
| wr_data | input | 8 | Byte to store |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The acknowledge command and a level-mode terminal count can land on the same clock edge. The bench provokes this by enabling level mode with a five-cycle interval and applying the acknowledge exactly on the fourth terminal-count edge. The outcome is judged at the pins: the line must stay low on that cycle and the next, and a later acknowledge must then release it. A top-byte write is also placed between two terminal counts, to show that it pre-empts the count the old value would have produced.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

    localparam logic [3:0] CMD_ACK       = 4'b1000;
    localparam logic [3:0] CMD_LEVEL_ON  = 4'b1010;
    localparam logic [3:0] CMD_EDGE_ON   = 4'b1110;
    localparam logic [3:0] CMD_ALL_OFF   = 4'b1100;

    typedef enum logic [1:0] {
        TM_OFF   = 2'd0,
        TM_LEVEL = 2'd1,
        TM_EDGE  = 2'd2
    } tmr_mode_e;

    typedef struct packed {
        logic ack;
        logic go_level;
        logic go_edge;
        logic go_off;
    } tmr_cmd_t;

    function automatic tmr_cmd_t decode_cmd(input logic valid, input logic [3:0] code);
        tmr_cmd_t c;
        c.ack      = valid && (code == CMD_ACK);
        c.go_level = valid && (code == CMD_LEVEL_ON);
        c.go_edge  = valid && (code == CMD_EDGE_ON);
        c.go_off   = valid && (code == CMD_ALL_OFF);
        return c;
    endfunction

    function automatic logic is_mode_cmd(input tmr_cmd_t c);
        return c.go_level || c.go_edge || c.go_off;
    endfunction

    function automatic tmr_mode_e next_mode(input tmr_mode_e cur, input tmr_cmd_t c);
        tmr_mode_e m;
        m = cur;
        if (c.go_off)
            m = TM_OFF;
        else if (c.go_level)
            m = TM_LEVEL;
        else if (c.go_edge)
            m = TM_EDGE;
        return m;
    endfunction

endpackage

// File: rtl/rtt_reload_regs.sv
module rtt_reload_regs #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    parameter int SEL_W     = 2,
    localparam int CNT_W    = BYTE_W * NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  rv_q,
    output logic [CNT_W-1:0]  rv_next,
    output logic              msb_load
);

    logic [NUM_BYTES-1:0]             hit;
    logic [NUM_BYTES-1:0][BYTE_W-1:0] lane_q;

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
        assign hit[i] = wr_en && (wr_sel == SEL_W'(i));
        assign rv_q[i*BYTE_W +: BYTE_W]    = lane_q[i];
        assign rv_next[i*BYTE_W +: BYTE_W] = hit[i] ? wr_data : lane_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
        end else begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                if (hit[i])
                    lane_q[i] <= wr_data;
            end
        end
    end

    assign msb_load = hit[NUM_BYTES-1];

endmodule

// File: rtl/rtt_down_counter.sv
module rtt_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             msb_load,
    input  logic [CNT_W-1:0] rv_q,
    input  logic [CNT_W-1:0] rv_next,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tc_fire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic at_one;
    logic at_zero;

    assign at_one  = (cnt_q == ONE);
    assign at_zero = (cnt_q == '0);

    // terminal count only while running and not pre-empted by a top-byte load
    assign tc_fire = run && !msb_load && at_one;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!run || msb_load)
            cnt_q <= rv_next;
        else if (at_zero || at_one)
            cnt_q <= rv_q;
        else
            cnt_q <= cnt_q - ONE;
    end

endmodule

// File: rtl/rtt_irq_ctl.sv
module rtt_irq_ctl
    import rtt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tmr_cmd_t  cmd,
    input  logic      tc_fire,
    output tmr_mode_e mode_q,
    output logic      irq_n
);

    tmr_mode_e mode_d;
    logic      pend_q;
    logic      pend_d;
    logic      irq_n_d;

    always_comb begin
        mode_d = next_mode(mode_q, cmd);
        pend_d = 1'b0;
        if (mode_d == TM_LEVEL) begin
            // a new terminal count outranks an acknowledge on the same edge
            pend_d = tc_fire || (pend_q && !cmd.ack && !is_mode_cmd(cmd));
        end
        case (mode_d)
            TM_LEVEL: irq_n_d = !pend_d;
            TM_EDGE:  irq_n_d = !tc_fire;
            default:  irq_n_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= TM_OFF;
            pend_q <= 1'b0;
            irq_n  <= 1'b1;
        end else begin
            mode_q <= mode_d;
            pend_q <= pend_d;
            irq_n  <= irq_n_d;
        end
    end

endmodule

// File: rtl/reload_tick_timer.sv
module reload_tick_timer
    import rtt_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    parameter int SEL_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    output logic              irq_n
);

    localparam int CNT_W = BYTE_W * NUM_BYTES;

    logic [CNT_W-1:0] rv_q;
    logic [CNT_W-1:0] rv_next;
    logic             msb_load;
    logic [CNT_W-1:0] cnt_q;
    logic             tc_fire;
    tmr_mode_e        mode_q;
    tmr_cmd_t         cmd;

    assign cmd = decode_cmd(cmd_valid, cmd_code);

    rtt_reload_regs #(
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (NUM_BYTES),
        .SEL_W     (SEL_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rv_q     (rv_q),
        .rv_next  (rv_next),
        .msb_load (msb_load)
    );

    rtt_down_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (mode_q != TM_OFF),
        .msb_load (msb_load),
        .rv_q     (rv_q),
        .rv_next  (rv_next),
        .cnt_q    (cnt_q),
        .tc_fire  (tc_fire)
    );

    rtt_irq_ctl u_irq (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .tc_fire (tc_fire),
        .mode_q  (mode_q),
        .irq_n   (irq_n)
    );

endmodule

// File: rtl/rtt_checker.sv
module rtt_checker
    import rtt_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    parameter int SEL_W     = 2,
    localparam int CNT_W    = BYTE_W * NUM_BYTES
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic             cmd_valid,
    input logic [3:0]       cmd_code,
    input logic             irq_n,
    input tmr_mode_e        mode_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] rv_q,
    input logic             tc_fire
);

    localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(NUM_BYTES - 1);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> irq_n); // R1

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        tc_fire |=> (cnt_q == $past(rv_q))); // R2

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (mode_q == TM_EDGE && !irq_n && !tc_fire) |=> irq_n); // R3

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_q == TM_LEVEL && !irq_n && !(cmd_valid && cmd_code[3])) |=> !irq_n); // R4

    AST_LOW_BYTE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel < TOP_SEL && mode_q != TM_OFF && cnt_q > CNT_W'(1))
        |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5

    AST_TOP_BYTE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == TOP_SEL) |=> (cnt_q == rv_q)); // R6

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mode_q == TM_OFF) |-> irq_n); // R7

    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (rv_q == '0 && cnt_q == '0) |-> !tc_fire); // R8

endmodule

bind reload_tick_timer rtt_checker #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES),
    .SEL_W     (SEL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .irq_n     (irq_n),
    .mode_q    (mode_q),
    .cnt_q     (cnt_q),
    .rv_q      (rv_q),
    .tc_fire   (tc_fire)
);

// File: tb/sim_reload_tick_timer.sv
`timescale 1ns/1ps
module sim_reload_tick_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = 4'd0;
    logic       irq_n;

    reload_tick_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .irq_n     (irq_n)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        logic  val;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    task automatic expect_irq(input int at, input logic val, input string tag);
        exp_t e;
        int   i;
        e.at  = at;
        e.val = val;
        e.tag = tag;
        i = 0;
        while (i < sb.size() && sb[i].at <= at) i++;
        sb.insert(i, e);
    endtask

    // monitor: compare scheduled expectations away from the active edge
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            n_chk++;
            if (e.at < cyc) begin
                n_err++;
                $display("FAIL %s: missed sample at cycle %0d, actual=n/a expected=%0b", e.tag, e.at, e.val);
            end else if (irq_n !== e.val) begin
                n_err++;
                $display("FAIL %s: cycle %0d irq_n actual=%0b expected=%0b", e.tag, cyc, irq_n, e.val);
            end
        end
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // apply a command so that it is captured on edge x
    task automatic cmd_at(input int x, input logic [3:0] code);
        wait_until(x - 1);
        cmd_valid = 1'b1;
        cmd_code  = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 4'd0;
    endtask

    task automatic wr_at(input int x, input logic [1:0] sel, input logic [7:0] data);
        wait_until(x - 1);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_sel  = 2'd0;
        wr_data = 8'd0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        wait (cyc >= 3000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: cycle actual=%0d expected=<3000", cyc);
            finish_run();
        end
    end

    initial begin
        int b;
        int e;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: quiet after reset
        expect_irq(cyc + 1, 1'b1, "R1 idle after reset");
        expect_irq(cyc + 8, 1'b1, "R1 idle after reset, later");
        wait_until(cyc + 9);

        // Test A: edge mode, interval 5
        b = cyc;
        e = b + 5;
        expect_irq(e + 4, 1'b1, "R7 no tick before one full period");
        expect_irq(e + 5, 1'b0, "R7 first tick one period after enable");
        expect_irq(e + 6, 1'b1, "R3 edge pulse lasts one cycle");
        expect_irq(e + 9, 1'b1, "R2 quiet between ticks");
        expect_irq(e + 10, 1'b0, "R2 second tick after 5 cycles");
        expect_irq(e + 11, 1'b1, "R3 edge pulse lasts one cycle");
        expect_irq(e + 15, 1'b0, "R2 third tick");
        expect_irq(e + 17, 1'b1, "R7 off command holds output high");
        expect_irq(e + 20, 1'b1, "R7 no ticks while off");
        wr_at(b + 1, 2'd0, 8'd5);
        wr_at(b + 2, 2'd1, 8'd0);
        wr_at(b + 3, 2'd2, 8'd0);
        cmd_at(e, 4'b1110);
        cmd_at(e + 17, 4'b1100);
        wait_until(e + 22);

        // Test B: level mode, interval 5, acknowledge handling
        b = cyc;
        e = b + 2;
        expect_irq(e + 4, 1'b1, "R7 level: quiet for one period");
        expect_irq(e + 5, 1'b0, "R4 level goes low at tick");
        expect_irq(e + 9, 1'b0, "R4 level stays low without ack");
        expect_irq(e + 10, 1'b0, "R9 second tick while pending");
        expect_irq(e + 12, 1'b1, "R9 single ack releases");
        expect_irq(e + 14, 1'b1, "R9 nothing queued");
        expect_irq(e + 15, 1'b0, "R4 next tick goes low");
        expect_irq(e + 20, 1'b0, "R10 ack on tick edge: tick wins");
        expect_irq(e + 21, 1'b0, "R10 still pending");
        expect_irq(e + 22, 1'b1, "R4 ack releases");
        expect_irq(e + 25, 1'b0, "R4 low again at tick");
        expect_irq(e + 27, 1'b1, "R12 mode command clears pending");
        expect_irq(e + 30, 1'b0, "R3 edge pulse after mode switch");
        expect_irq(e + 31, 1'b1, "R3 edge pulse one cycle");
        expect_irq(e + 32, 1'b1, "R7 off command");
        cmd_at(e, 4'b1010);
        cmd_at(e + 12, 4'b1000);
        cmd_at(e + 20, 4'b1000);
        cmd_at(e + 22, 4'b1000);
        cmd_at(e + 27, 4'b1110);
        cmd_at(e + 32, 4'b1100);
        wait_until(e + 34);

        // Test C: byte writes while running in edge mode
        b = cyc;
        e = b + 2;
        expect_irq(e + 10, 1'b0, "R5 low byte write leaves countdown");
        expect_irq(e + 11, 1'b1, "R3 edge pulse one cycle");
        expect_irq(e + 18, 1'b1, "R5 new value used on reload");
        expect_irq(e + 19, 1'b0, "R5 tick after new interval 9");
        expect_irq(e + 28, 1'b1, "R6 top byte write pre-empts old tick");
        expect_irq(e + 30, 1'b1, "R6 quiet before reloaded period ends");
        expect_irq(e + 31, 1'b0, "R6 tick 9 cycles after top byte write");
        expect_irq(e + 40, 1'b0, "R5 tick with old value still counting");
        expect_irq(e + 42, 1'b1, "R5 quiet before new interval 3");
        expect_irq(e + 43, 1'b0, "R5 tick after interval 3");
        cmd_at(e, 4'b1110);
        wr_at(e + 7, 2'd0, 8'd9);
        wr_at(e + 22, 2'd2, 8'd0);
        wr_at(e + 33, 2'd0, 8'd3);
        cmd_at(e + 45, 4'b1100);
        wait_until(e + 47);

        // Test D: zero value, ignored inputs, restart from zero
        b = cyc;
        e = b + 3;
        expect_irq(e + 5, 1'b1, "R8 zero value gives no tick");
        expect_irq(e + 20, 1'b1, "R8 zero value gives no tick");
        expect_irq(e + 30, 1'b1, "R11 lane 3 write and unknown code ignored");
        expect_irq(e + 40, 1'b1, "R8 still stopped");
        expect_irq(e + 47, 1'b1, "R8 restart loads first");
        expect_irq(e + 48, 1'b0, "R8 tick after restart from zero");
        expect_irq(e + 49, 1'b1, "R3 edge pulse one cycle");
        expect_irq(e + 50, 1'b0, "R2 interval 2");
        wr_at(b + 1, 2'd0, 8'd0);
        cmd_at(e, 4'b1110);
        wr_at(e + 10, 2'd3, 8'd5);
        cmd_at(e + 12, 4'b0110);
        cmd_at(e + 14, 4'b1001);
        wr_at(e + 45, 2'd0, 8'd2);
        cmd_at(e + 52, 4'b1100);
        wait_until(e + 54);

        while (sb.size() > 0) @(negedge clk);
        finish_run();
    end

endmodule